// File: doc/BRIEF.md
# Register Status Table with Tag-Matched Writeback

This block holds the architectural register values of an out-of-order core together with a binding table. The binding table records, for each register, which execution station will deliver that register's newest value. A register whose binding is empty holds its current value in the register file. A register with a non-zero binding is waiting for the station named by that tag.

At issue the block looks up two source registers at once, with no clock delay. For each source it returns either a ready value with a zero tag or a producer tag. On the clock edge of the issue it binds the destination register to the tag of the issuing station. It also watches the single result broadcast bus. A broadcast updates a register only when that register is still bound to the broadcast tag, so results from writers that have since been superseded are dropped without any action. A preload port lets the register values be set before a run; it does not touch any binding.

Top module: `regstat_bind_unit`

## Requirements
- R1: After a synchronous reset, every binding is empty and every register value is zero, so every lookup returns value 0 and tag 0.
- R2: A lookup of a register with an empty binding (tag 0) returns the stored register value and tag 0.
- R3: A lookup of a register bound to a non-zero tag, while no matching broadcast is present, returns that tag and value 0. Two ports that read the same pending register both return the tag.
- R4: An issue (iss_valid high, iss_tag non-zero) sets the binding of iss_dst to iss_tag on the next edge. Any earlier binding is replaced.
- R5: Lookups made in the same cycle as an issue see the bindings from before that issue, even when a source equals the destination.
- R6: A broadcast (bus_valid high, bus_tag non-zero) that equals a register's binding writes bus_data into that register and clears the binding on the next edge.
- R7: A broadcast whose tag differs from a register's binding leaves both the register's value and its binding unchanged. A broadcast with tag 0 changes nothing.
- R8: If an issue binds a register in the same cycle that a broadcast clears it, the register ends up bound to the new issue tag.
- R9: A lookup of a register whose binding equals the tag on the bus in that cycle returns bus_data with tag 0.
- R10: A preload write (pre_we high) sets the value of register pre_idx on the next edge and leaves every binding unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_src_a | input | IDX_W (4) | First source register index |
| iss_src_b | input | IDX_W (4) | Second source register index |
| iss_dst | input | IDX_W (4) | Destination register to bind |
| iss_tag | input | TAG_W (4) | Tag of the issuing station, non-zero |
| rd_a_val | output | DATA_W (32) | First source value, valid when rd_a_tag is 0 |
| rd_a_tag | output | TAG_W (4) | First source producer tag, 0 when ready |
| rd_b_val | output | DATA_W (32) | Second source value, valid when rd_b_tag is 0 |
| rd_b_tag | output | TAG_W (4) | Second source producer tag, 0 when ready |
| bus_valid | input | 1 | Result broadcast present |
| bus_tag | input | TAG_W (4) | Tag of the station broadcasting |
| bus_data | input | DATA_W (32) | Broadcast result value |
| pre_we | input | 1 | Preload write enable for a register value |
| pre_idx | input | IDX_W (4) | Preload register index |
| pre_data | input | DATA_W (32) | Preload value |

## Verification
A binding that is wrong shows up on the lookup ports in the cycle right after the issue or broadcast that caused it. A lost clear returns a tag where a value should be. A stale write returns an old producer's data once the correct binding has cleared. A missed same-cycle bypass shows up combinationally in the broadcast cycle itself. Each scenario therefore reads back the affected registers through the two source ports both before and after the edge that changes them.

// File: rtl/regstat_pkg.sv
package regstat_pkg;
    localparam int unsigned RS_NREGS_DEF  = 16;
    localparam int unsigned RS_DATA_W_DEF = 32;
    localparam int unsigned RS_TAG_W_DEF  = 4;

    // Where a source lookup takes its answer from.
    typedef enum logic [1:0] {
        SRC_FILE    = 2'd0,
        SRC_BYPASS  = 2'd1,
        SRC_PENDING = 2'd2
    } src_kind_e;

    // A tag of zero means "no producer".
    function automatic logic tag_live(input logic [7:0] tag);
        return tag != 8'd0;
    endfunction
endpackage

// File: rtl/regstat_table.sv
module regstat_table
    import regstat_pkg::*;
#(
    parameter int unsigned NREGS = RS_NREGS_DEF,
    parameter int unsigned TAG_W = RS_TAG_W_DEF,
    localparam int unsigned IDX_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             iss_valid,
    input  logic [IDX_W-1:0] iss_dst,
    input  logic [TAG_W-1:0] iss_tag,
    input  logic             bus_valid,
    input  logic [TAG_W-1:0] bus_tag,
    output logic [TAG_W-1:0] stat_q [NREGS],
    output logic             hit_vec [NREGS]
);
    for (genvar k = 0; k < NREGS; k++) begin : g_entry
        logic bind_here;

        always_comb begin
            hit_vec[k] = bus_valid && tag_live(8'(stat_q[k])) && (stat_q[k] == bus_tag);
            bind_here  = iss_valid && (iss_dst == IDX_W'(k));
        end

        // A new binding from issue takes priority over a clear from the bus.
        always_ff @(posedge clk) begin
            if (rst) begin
                stat_q[k] <= '0;
            end else if (bind_here) begin
                stat_q[k] <= iss_tag;
            end else if (hit_vec[k]) begin
                stat_q[k] <= '0;
            end
        end
    end
endmodule

// File: rtl/regstat_valfile.sv
module regstat_valfile
    import regstat_pkg::*;
#(
    parameter int unsigned NREGS  = RS_NREGS_DEF,
    parameter int unsigned DATA_W = RS_DATA_W_DEF,
    localparam int unsigned IDX_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit_vec [NREGS],
    input  logic [DATA_W-1:0] bus_data,
    input  logic              pre_we,
    input  logic [IDX_W-1:0]  pre_idx,
    input  logic [DATA_W-1:0] pre_data,
    output logic [DATA_W-1:0] val_q [NREGS]
);
    for (genvar k = 0; k < NREGS; k++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                val_q[k] <= '0;
            end else if (hit_vec[k]) begin
                val_q[k] <= bus_data;
            end else if (pre_we && (pre_idx == IDX_W'(k))) begin
                val_q[k] <= pre_data;
            end
        end
    end
endmodule

// File: rtl/regstat_lookup.sv
module regstat_lookup
    import regstat_pkg::*;
#(
    parameter int unsigned NREGS  = RS_NREGS_DEF,
    parameter int unsigned DATA_W = RS_DATA_W_DEF,
    parameter int unsigned TAG_W  = RS_TAG_W_DEF,
    localparam int unsigned IDX_W = $clog2(NREGS)
) (
    input  logic [IDX_W-1:0]  src,
    input  logic [TAG_W-1:0]  stat_q [NREGS],
    input  logic [DATA_W-1:0] val_q [NREGS],
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_data,
    output logic [DATA_W-1:0] out_val,
    output logic [TAG_W-1:0]  out_tag
);
    logic [TAG_W-1:0] cur_tag;
    src_kind_e        kind;

    always_comb begin
        cur_tag = stat_q[src];
        if (!tag_live(8'(cur_tag))) begin
            kind = SRC_FILE;
        end else if (bus_valid && (cur_tag == bus_tag)) begin
            kind = SRC_BYPASS;
        end else begin
            kind = SRC_PENDING;
        end

        unique case (kind)
            SRC_FILE: begin
                out_val = val_q[src];
                out_tag = '0;
            end
            SRC_BYPASS: begin
                out_val = bus_data;
                out_tag = '0;
            end
            default: begin
                out_val = '0;
                out_tag = cur_tag;
            end
        endcase
    end
endmodule

// File: rtl/regstat_bind_unit.sv
module regstat_bind_unit
    import regstat_pkg::*;
#(
    parameter int unsigned NREGS  = RS_NREGS_DEF,
    parameter int unsigned DATA_W = RS_DATA_W_DEF,
    parameter int unsigned TAG_W  = RS_TAG_W_DEF,
    localparam int unsigned IDX_W = $clog2(NREGS),
    localparam int unsigned NPORT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    input  logic [IDX_W-1:0]  iss_src_a,
    input  logic [IDX_W-1:0]  iss_src_b,
    input  logic [IDX_W-1:0]  iss_dst,
    input  logic [TAG_W-1:0]  iss_tag,
    output logic [DATA_W-1:0] rd_a_val,
    output logic [TAG_W-1:0]  rd_a_tag,
    output logic [DATA_W-1:0] rd_b_val,
    output logic [TAG_W-1:0]  rd_b_tag,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              pre_we,
    input  logic [IDX_W-1:0]  pre_idx,
    input  logic [DATA_W-1:0] pre_data
);
    logic [TAG_W-1:0]  stat_q  [NREGS];
    logic              hit_vec [NREGS];
    logic [DATA_W-1:0] val_q   [NREGS];
    logic [IDX_W-1:0]  port_src [NPORT];
    logic [DATA_W-1:0] port_val [NPORT];
    logic [TAG_W-1:0]  port_tag [NPORT];

    regstat_table #(.NREGS(NREGS), .TAG_W(TAG_W)) table_i (
        .clk       (clk),
        .rst       (rst),
        .iss_valid (iss_valid),
        .iss_dst   (iss_dst),
        .iss_tag   (iss_tag),
        .bus_valid (bus_valid),
        .bus_tag   (bus_tag),
        .stat_q    (stat_q),
        .hit_vec   (hit_vec)
    );

    regstat_valfile #(.NREGS(NREGS), .DATA_W(DATA_W)) file_i (
        .clk      (clk),
        .rst      (rst),
        .hit_vec  (hit_vec),
        .bus_data (bus_data),
        .pre_we   (pre_we),
        .pre_idx  (pre_idx),
        .pre_data (pre_data),
        .val_q    (val_q)
    );

    assign port_src[0] = iss_src_a;
    assign port_src[1] = iss_src_b;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        regstat_lookup #(.NREGS(NREGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) look_i (
            .src       (port_src[p]),
            .stat_q    (stat_q),
            .val_q     (val_q),
            .bus_valid (bus_valid),
            .bus_tag   (bus_tag),
            .bus_data  (bus_data),
            .out_val   (port_val[p]),
            .out_tag   (port_tag[p])
        );
    end

    assign rd_a_val = port_val[0];
    assign rd_a_tag = port_tag[0];
    assign rd_b_val = port_val[1];
    assign rd_b_tag = port_tag[1];
endmodule

// File: rtl/regstat_checker.sv
module regstat_checker #(
    parameter int unsigned NREGS  = 16,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned TAG_W  = 4,
    localparam int unsigned IDX_W = $clog2(NREGS)
) (
    input logic              clk,
    input logic              rst,
    input logic              iss_valid,
    input logic [IDX_W-1:0]  iss_src_a,
    input logic [IDX_W-1:0]  iss_dst,
    input logic [TAG_W-1:0]  iss_tag,
    input logic [DATA_W-1:0] rd_a_val,
    input logic [TAG_W-1:0]  rd_a_tag,
    input logic              bus_valid,
    input logic [TAG_W-1:0]  bus_tag,
    input logic [DATA_W-1:0] bus_data,
    input logic              pre_we,
    input logic [IDX_W-1:0]  pre_idx,
    input logic [TAG_W-1:0]  stat_q [NREGS],
    input logic [DATA_W-1:0] val_q [NREGS]
);
    // R4: an issuing station always carries a live tag
    a_r4_live_issue_tag: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> iss_tag != '0);

    // R4 / R8: after an issue the destination holds the issuing tag
    a_r4_bind_dst: assert property (@(posedge clk) disable iff (rst)
        iss_valid |=> stat_q[$past(iss_dst)] == $past(iss_tag));

    // R9: source whose binding is on the bus gets the bus value
    a_r9_bypass: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_tag != '0 && stat_q[iss_src_a] == bus_tag)
        |-> (rd_a_tag == '0 && rd_a_val == bus_data));

    // R5: lookup sees the binding from before the same-cycle issue
    a_r5_old_binding: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_src_a == iss_dst && stat_q[iss_dst] != '0 && !bus_valid)
        |-> rd_a_tag == stat_q[iss_dst]);

    for (genvar k = 0; k < NREGS; k++) begin : g_reg
        // R1: reset empties every binding and value
        a_r1_reset_clear: assert property (@(posedge clk)
            rst |=> (stat_q[k] == '0 && val_q[k] == '0));

        // R6: matching broadcast writes the value and clears the binding
        a_r6_match_write: assert property (@(posedge clk) disable iff (rst)
            (bus_valid && bus_tag != '0 && stat_q[k] == bus_tag
             && !(iss_valid && iss_dst == IDX_W'(k)))
            |=> (stat_q[k] == '0 && val_q[k] == $past(bus_data)));

        // R7 / R10: without a match or preload the value is held
        a_r7_value_held: assert property (@(posedge clk) disable iff (rst)
            (!(bus_valid && bus_tag != '0 && stat_q[k] == bus_tag)
             && !(pre_we && pre_idx == IDX_W'(k)))
            |=> $stable(val_q[k]));

        // R7 / R10: without a match or issue the binding is held
        a_r7_binding_held: assert property (@(posedge clk) disable iff (rst)
            (!(bus_valid && bus_tag != '0 && stat_q[k] == bus_tag)
             && !(iss_valid && iss_dst == IDX_W'(k)))
            |=> $stable(stat_q[k]));
    end
endmodule

bind regstat_bind_unit regstat_checker #(
    .NREGS(NREGS), .DATA_W(DATA_W), .TAG_W(TAG_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .iss_valid (iss_valid),
    .iss_src_a (iss_src_a),
    .iss_dst   (iss_dst),
    .iss_tag   (iss_tag),
    .rd_a_val  (rd_a_val),
    .rd_a_tag  (rd_a_tag),
    .bus_valid (bus_valid),
    .bus_tag   (bus_tag),
    .bus_data  (bus_data),
    .pre_we    (pre_we),
    .pre_idx   (pre_idx),
    .stat_q    (stat_q),
    .val_q     (val_q)
);

// File: tb/regstat_bind_unit_tb_top.sv
`timescale 1ns/1ps
module regstat_bind_unit_tb_top;
    localparam int unsigned NREGS  = 16;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned TAG_W  = 4;
    localparam int unsigned IDX_W  = $clog2(NREGS);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              iss_valid = 1'b0;
    logic [IDX_W-1:0]  iss_src_a = '0, iss_src_b = '0, iss_dst = '0;
    logic [TAG_W-1:0]  iss_tag = '0;
    logic [DATA_W-1:0] rd_a_val, rd_b_val;
    logic [TAG_W-1:0]  rd_a_tag, rd_b_tag;
    logic              bus_valid = 1'b0;
    logic [TAG_W-1:0]  bus_tag = '0;
    logic [DATA_W-1:0] bus_data = '0;
    logic              pre_we = 1'b0;
    logic [IDX_W-1:0]  pre_idx = '0;
    logic [DATA_W-1:0] pre_data = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    regstat_bind_unit #(.NREGS(NREGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) dut_i (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
        .iss_dst(iss_dst), .iss_tag(iss_tag),
        .rd_a_val(rd_a_val), .rd_a_tag(rd_a_tag),
        .rd_b_val(rd_b_val), .rd_b_tag(rd_b_tag),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
        .pre_we(pre_we), .pre_idx(pre_idx), .pre_data(pre_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Cross one rising edge; return just after the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        iss_valid = 1'b0; bus_valid = 1'b0; pre_we = 1'b0;
        bus_tag = '0; iss_tag = '0;
    endtask

    task automatic look(input int a, input int b);
        iss_src_a = IDX_W'(a);
        iss_src_b = IDX_W'(b);
        #1;
    endtask

    task automatic t_reset();
        for (int k = 0; k < NREGS; k += 2) begin
            look(k, k + 1);
            chk("R1", "val a", rd_a_val, '0);
            chk("R1", "tag a", 32'(rd_a_tag), '0);
            chk("R1", "val b", rd_b_val, '0);
            chk("R1", "tag b", 32'(rd_b_tag), '0);
        end
    endtask

    task automatic t_preload();
        for (int k = 1; k < 12; k++) begin
            pre_we = 1'b1; pre_idx = IDX_W'(k); pre_data = 32'h1000_0000 + 32'(k * 17);
            step();
        end
        pre_we = 1'b0;
        look(3, 7);
        chk("R10", "r3 val", rd_a_val, 32'h1000_0033);
        chk("R2", "r7 val", rd_b_val, 32'h1000_0077);
        chk("R10", "r3 tag stays empty", 32'(rd_a_tag), '0);
    endtask

    task automatic t_issue_old_binding();
        // Issue dst=5 tag=2 while reading 5 and 3 in the same cycle
        iss_valid = 1'b1; iss_dst = 4'd5; iss_tag = 4'd2;
        look(5, 3);
        chk("R5", "src=dst sees old value", rd_a_val, 32'h1000_0055);
        chk("R5", "src=dst old tag", 32'(rd_a_tag), '0);
        chk("R2", "r3 val", rd_b_val, 32'h1000_0033);
        step(); idle();
        look(5, 3);
        chk("R3", "r5 pending tag", 32'(rd_a_tag), 32'd2);
        chk("R3", "r5 pending val", rd_a_val, '0);
        // Second issue to r5 by a different station, reading r5 itself
        iss_valid = 1'b1; iss_dst = 4'd5; iss_tag = 4'd7;
        look(5, 5);
        chk("R5", "src=dst sees prior tag", 32'(rd_a_tag), 32'd2);
        step(); idle();
        look(5, 5);
        chk("R4", "r5 rebound tag a", 32'(rd_a_tag), 32'd7);
        chk("R3", "r5 rebound tag b", 32'(rd_b_tag), 32'd7);
    endtask

    task automatic t_stale_and_match();
        // Stale broadcast from tag 2 (superseded)
        bus_valid = 1'b1; bus_tag = 4'd2; bus_data = 32'hDEAD_0002;
        look(5, 3);
        chk("R7", "no bypass on stale tag", 32'(rd_a_tag), 32'd7);
        step(); idle();
        look(5, 3);
        chk("R7", "r5 still bound after stale", 32'(rd_a_tag), 32'd7);
        chk("R7", "r3 untouched", rd_b_val, 32'h1000_0033);
        // Tag-0 broadcast changes nothing
        bus_valid = 1'b1; bus_tag = 4'd0; bus_data = 32'hFFFF_FFFF;
        step(); idle();
        look(3, 4);
        chk("R7", "tag0 r3", rd_a_val, 32'h1000_0033);
        chk("R7", "tag0 r4", rd_b_val, 32'h1000_0044);
        // Matching broadcast: same-cycle bypass, then writeback
        bus_valid = 1'b1; bus_tag = 4'd7; bus_data = 32'hBEEF_0007;
        look(5, 6);
        chk("R9", "bypass val", rd_a_val, 32'hBEEF_0007);
        chk("R9", "bypass tag", 32'(rd_a_tag), '0);
        chk("R2", "r6 not on bus", rd_b_val, 32'h1000_0066);
        step(); idle();
        look(5, 6);
        chk("R6", "r5 written", rd_a_val, 32'hBEEF_0007);
        chk("R6", "r5 cleared", 32'(rd_a_tag), '0);
    endtask

    task automatic t_issue_vs_clear();
        iss_valid = 1'b1; iss_dst = 4'd9; iss_tag = 4'd3;
        step(); idle();
        // Same cycle: broadcast of tag 3 and rebinding of r9 to tag 4
        iss_valid = 1'b1; iss_dst = 4'd9; iss_tag = 4'd4;
        bus_valid = 1'b1; bus_tag = 4'd3; bus_data = 32'h0000_0099;
        step(); idle();
        look(9, 9);
        chk("R8", "new binding wins", 32'(rd_a_tag), 32'd4);
        bus_valid = 1'b1; bus_tag = 4'd4; bus_data = 32'h0000_0444;
        step(); idle();
        look(9, 8);
        chk("R6", "r9 final", rd_a_val, 32'h0000_0444);
        chk("R7", "r8 untouched", rd_b_val, 32'h1000_0088);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step();
        rst = 1'b0;
        t_reset();
        t_preload();
        t_issue_old_binding();
        t_stale_and_match();
        t_issue_vs_clear();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule